// File: doc/BRIEF.md
# Monochrome Scanline Serializer with Pixel Doubling

This block turns a one-bit-per-pixel framebuffer into a serial video stream, one scanline at a time. An external timing generator sends a line pulse together with the current line number. If that line falls inside the vertical active window and the block is enabled, the block starts a line transfer. It reads one row of framebuffer words from a synchronous-read memory port and shifts each word out least significant bit first. Each bit is held for two pixel clocks, so a 320-bit row covers 640 screen pixels.

Every line opens with an all-zero word, which gives 32 blank pixels of lead-in. The transfer therefore has one word more than the framebuffer row: for a 40-byte row this is (40 + 2) / 2 = 21 words. The block keeps a row pointer. The pointer goes back to the framebuffer base on any line pulse outside the active window. Inside the window it moves forward by one stride after every line whose offset from the window start is odd. As a result each source row appears on two consecutive scanlines.

Top module: `mono_scanout`

## Requirements
- R1: After reset, `pix_out` is 0 and `rd_en` is 0 until a qualifying line pulse arrives.
- R2: Line transfer begins here: in the cycles 0 to 31 after the edge that samples `line_trig`, `pix_out` is 0 (the zero lead-in word).
- R3: Framebuffer bits go out least significant bit first, and each bit lasts two clocks. In cycle c of a line (32 <= c < 32*XFER), `pix_out` equals bit ((c mod 32) / 2) of framebuffer word (c/32 - 1) of the row.
- R4: A transfer lasts exactly ROW_WORDS+1 words (32*(ROW_WORDS+1) cycles). After that, `pix_out` stays 0 until the next transfer.
- R5: For framebuffer word k of the row, `rd_en` is high for one cycle, in line cycle 32*k + 30, with `rd_addr` = row base + k. `rd_data` is captured on the following edge. Exactly ROW_WORDS reads are made per full line.
- R6: A line pulse with a line number outside [VBLANK_END, VBLANK_END+VACTIVE) starts no transfer: no `rd_en`, and `pix_out` stays 0.
- R7: A line pulse outside the window sets the row pointer back to FB_BASE, so the next in-window line reads from FB_BASE.
- R8: A line pulse inside the window uses the current row pointer. When (line - VBLANK_END) is odd, the pointer then moves forward by STRIDE words, so each row shows on two lines.
- R9: When `enable` is 0 at a line pulse, no transfer starts. The row pointer still follows R7 and R8.
- R10: When `enable` drops during a transfer, the current word finishes. `pix_out` is 0 from the next word boundary on, and no further reads are made.
- R11: An in-window line pulse that arrives during a transfer restarts the transfer at once from the lead-in word, using the current row pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new transfers; clearing it ends a transfer at the next word boundary |
| line_trig | input | 1 | One-cycle line start pulse from the timing generator |
| line_num | input | LINE_W | Line number that goes with `line_trig` |
| rd_en | output | 1 | Framebuffer read strobe |
| rd_addr | output | ADDR_W | Framebuffer word address |
| rd_data | input | WORD_W | Read data, valid the cycle after `rd_en` |
| pix_out | output | 1 | Serial pixel output |

## Verification
The assertions assume that `line_trig` is a single-cycle pulse and that `rd_data` arrives exactly one clock after the `rd_en` that requested it. The bench drives every pulse for exactly one edge, changing inputs on the falling edge, and its memory model registers a value computed from the address on the edge that sees `rd_en`. The bench also assumes that `enable` only changes between line pulses or in the middle of a word. The shutdown scenario changes it in the middle of a word, well away from a line pulse.

// File: rtl/mono_scan_pkg.sv
package mono_scan_pkg;

  // number of words sent per line: lead-in zero word plus the row
  function automatic int unsigned line_xfer_words(input int unsigned row_words);
    return row_words + 1;
  endfunction

  // true when a line number lies inside the vertical active window
  function automatic logic line_in_window(input logic [31:0] line,
                                          input int unsigned vb_end,
                                          input int unsigned v_active);
    return (line >= vb_end) && (line < vb_end + v_active);
  endfunction

  // true when the row pointer steps after this line
  function automatic logic line_steps_row(input logic [31:0] line,
                                          input int unsigned vb_end);
    logic [31:0] rel;
    rel = line - vb_end;
    return rel[0];
  endfunction

endpackage

// File: rtl/scan_row_tracker.sv
module scan_row_tracker
  import mono_scan_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_W     = 10,
  parameter int FB_BASE    = 256,
  parameter int STRIDE     = 24,
  parameter int VBLANK_END = 15,
  parameter int VACTIVE    = 480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_trig,
  input  logic [LINE_W-1:0] line_num,
  input  logic              enable,
  output logic              in_win,
  output logic              start_req,
  output logic [ADDR_W-1:0] row_base
);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(FB_BASE);
  localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] ptr_q;
  logic              steps;

  assign in_win    = line_in_window(32'(line_num), VBLANK_END, VACTIVE);
  assign steps     = line_steps_row(32'(line_num), VBLANK_END);
  assign start_req = line_trig && in_win && enable;
  assign row_base  = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= BASE_A;
    end else if (line_trig) begin
      if (!in_win)    ptr_q <= BASE_A;
      else if (steps) ptr_q <= ptr_q + STRIDE_A;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_trig |=> $stable(ptr_q)); // R8

endmodule

// File: rtl/scan_bit_serializer.sv
module scan_bit_serializer #(
  parameter int WORD_W     = 16,
  parameter int XFER_WORDS = 21,
  parameter int IDX_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              enable,
  input  logic [WORD_W-1:0] load_data,
  output logic              active,
  output logic [IDX_W-1:0]  word_idx,
  output logic              pre_edge,
  output logic              word_end,
  output logic              pix
);
  localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(XFER_WORDS - 1);

  logic              act_q;
  logic [WORD_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;
  logic              phase_q;
  logic [IDX_W-1:0]  idx_q;

  assign active   = act_q;
  assign word_idx = idx_q;
  assign pre_edge = act_q && !phase_q && (bit_q == LAST_BIT);
  assign word_end = act_q &&  phase_q && (bit_q == LAST_BIT);
  assign pix      = act_q && sh_q[bit_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      sh_q    <= '0;
      bit_q   <= '0;
      phase_q <= 1'b0;
      idx_q   <= '0;
    end else if (start) begin
      act_q   <= 1'b1;
      sh_q    <= '0;
      bit_q   <= '0;
      phase_q <= 1'b0;
      idx_q   <= '0;
    end else if (act_q) begin
      phase_q <= !phase_q;
      if (phase_q) bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
      if (word_end) begin
        if ((idx_q == LAST_WORD) || !enable) begin
          act_q <= 1'b0;
        end else begin
          sh_q  <= load_data;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_LEADIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (sh_q == '0)); // R2

  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && !$past(start)) |-> (phase_q != $past(phase_q))); // R3

  AST_WORD_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (idx_q <= LAST_WORD)); // R4

endmodule

// File: rtl/scan_word_fetch.sv
module scan_word_fetch #(
  parameter int ADDR_W     = 12,
  parameter int IDX_W      = 5,
  parameter int XFER_WORDS = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] row_base,
  input  logic              pre_edge,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic              enable,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(XFER_WORDS - 1);

  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     base_q <= '0;
    else if (start) base_q <= row_base;
  end

  // transfer word idx+1 holds framebuffer word idx
  assign rd_en   = pre_edge && enable && !start && (word_idx != LAST_WORD);
  assign rd_addr = base_q + ADDR_W'(word_idx);

  AST_ADDR_STABLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(base_q)); // R5

endmodule

// File: rtl/mono_scanout.sv
module mono_scanout
  import mono_scan_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int ROW_WORDS  = 20,
  parameter int STRIDE     = 24,
  parameter int ADDR_W     = 12,
  parameter int LINE_W     = 10,
  parameter int FB_BASE    = 256,
  parameter int VBLANK_END = 15,
  parameter int VACTIVE    = 480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              line_trig,
  input  logic [LINE_W-1:0] line_num,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  output logic              pix_out
);
  localparam int XFER_WORDS = line_xfer_words(ROW_WORDS);
  localparam int IDX_W      = $clog2(XFER_WORDS + 1);

  logic              in_win;
  logic              start_req;
  logic [ADDR_W-1:0] row_base;
  logic              act;
  logic [IDX_W-1:0]  word_idx;
  logic              pre_edge;
  logic              word_end;

  scan_row_tracker #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .FB_BASE(FB_BASE), .STRIDE(STRIDE),
    .VBLANK_END(VBLANK_END), .VACTIVE(VACTIVE)
  ) u_rows (
    .clk(clk), .rst_n(rst_n), .line_trig(line_trig), .line_num(line_num),
    .enable(enable), .in_win(in_win), .start_req(start_req), .row_base(row_base)
  );

  scan_bit_serializer #(
    .WORD_W(WORD_W), .XFER_WORDS(XFER_WORDS), .IDX_W(IDX_W)
  ) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start_req), .enable(enable),
    .load_data(rd_data), .active(act), .word_idx(word_idx),
    .pre_edge(pre_edge), .word_end(word_end), .pix(pix_out)
  );

  scan_word_fetch #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .XFER_WORDS(XFER_WORDS)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start_req), .row_base(row_base),
    .pre_edge(pre_edge), .word_idx(word_idx), .enable(enable),
    .rd_en(rd_en), .rd_addr(rd_addr)
  );

  AST_FETCH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> word_end); // R5

  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> ($past(line_trig) && $past(in_win) && $past(enable))); // R6

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !rd_en); // R4

endmodule

// File: tb/mono_scanout_tb.sv
module mono_scanout_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 16;
  localparam int ROW_WORDS  = 20;
  localparam int STRIDE     = 24;
  localparam int ADDR_W     = 12;
  localparam int LINE_W     = 10;
  localparam int FB_BASE    = 256;
  localparam int VBE        = 15;
  localparam int VACT       = 480;
  localparam int XW         = ROW_WORDS + 1;
  localparam int LINE_CYC   = XW * 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b1;
  logic              line_trig = 1'b0;
  logic [LINE_W-1:0] line_num = '0;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data = '0;
  logic              pix_out;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mono_scanout #(
    .WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .STRIDE(STRIDE), .ADDR_W(ADDR_W),
    .LINE_W(LINE_W), .FB_BASE(FB_BASE), .VBLANK_END(VBE), .VACTIVE(VACT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .line_trig(line_trig),
    .line_num(line_num), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .pix_out(pix_out)
  );

  function automatic logic [WORD_W-1:0] pat(input logic [ADDR_W-1:0] a);
    logic [15:0] p;
    p = {4'h0, a} * 16'h9E37;
    return p ^ 16'h5A5A;
  endfunction

  // memory model: registered read one cycle after rd_en
  always_ff @(posedge clk) if (rd_en) rd_data <= pat(rd_addr);

  // runs one line; base is the expected row start, on says whether a transfer
  // should run, cut is the line cycle after which enable drops (-1 none),
  // stop is the number of cycles observed
  task automatic run_line(input int line, input int base, input bit on,
                          input int cut, input int stop, input string req);
    int lim, bad_pix, bad_fetch, reads, first_c;
    logic got_p, exp_p;
    logic exp_rd;
    logic [ADDR_W-1:0] exp_a;
    lim = !on ? 0 : (cut < 0 ? LINE_CYC : ((cut - 30 + 31) / 32 + 1) * 32);
    if (lim > LINE_CYC) lim = LINE_CYC;
    bad_pix = 0; bad_fetch = 0; reads = 0; first_c = -1;
    exp_p = 1'b0; got_p = 1'b0;
    line_trig = 1'b1;
    line_num  = LINE_W'(line);
    @(negedge clk);
    line_trig = 1'b0;
    for (int c = 0; c < stop; c++) begin
      logic e;
      e = 1'b0;
      if (c >= 32 && c < lim)
        e = pat(ADDR_W'(base + c / 32 - 1))[(c % 32) / 2];
      if (pix_out !== e) begin
        if (bad_pix == 0) begin first_c = c; got_p = pix_out; exp_p = e; end
        bad_pix++;
      end
      exp_rd = (c % 32 == 30) && (c / 32 + 1 < XW) && ((c / 32 + 1) * 32 < lim);
      exp_a  = ADDR_W'(base + c / 32);
      if (rd_en) reads++;
      if (rd_en !== exp_rd || (exp_rd && rd_addr !== exp_a)) begin
        if (bad_fetch == 0)
          $display("FAIL %s/R5 line %0d cycle %0d: rd_en=%b addr=%0h expected rd_en=%b addr=%0h",
                   req, line, c, rd_en, rd_addr, exp_rd, exp_a);
        bad_fetch++;
      end
      if (c == cut) enable = 1'b0;
      @(negedge clk);
    end
    n_vec++;
    if (bad_pix != 0) begin
      n_fail++;
      $display("FAIL %s line %0d: %0d pixel errors, first at cycle %0d actual %b expected %b",
               req, line, bad_pix, first_c, got_p, exp_p);
    end
    n_vec++;
    if (bad_fetch != 0) n_fail++;
  endtask

  task automatic t_reset();
    n_vec++;
    if (pix_out !== 1'b0 || rd_en !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: pix_out=%b rd_en=%b expected 0 0", pix_out, rd_en);
    end
    repeat (5) @(negedge clk);
    n_vec++;
    if (pix_out !== 1'b0 || rd_en !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: pix_out=%b rd_en=%b expected 0 0", pix_out, rd_en);
    end
  endtask

  task automatic t_outside();
    run_line(3, FB_BASE, 1'b0, -1, LINE_CYC + 8, "R6 below window");
    run_line(VBE + VACT, FB_BASE, 1'b0, -1, LINE_CYC + 8, "R6 above window");
  endtask

  task automatic t_frame();
    // R2 R3 R4 R8: rows twice each, lead-in and tail checked in every line
    run_line(VBE,     FB_BASE,              1'b1, -1, LINE_CYC + 8, "R3 line0");
    run_line(VBE + 1, FB_BASE,              1'b1, -1, LINE_CYC + 8, "R8 line1");
    run_line(VBE + 2, FB_BASE + STRIDE,     1'b1, -1, LINE_CYC + 8, "R8 line2");
    run_line(VBE + 3, FB_BASE + STRIDE,     1'b1, -1, LINE_CYC + 8, "R2 line3");
    run_line(VBE + 4, FB_BASE + 2 * STRIDE, 1'b1, -1, LINE_CYC + 40, "R4 line4");
  endtask

  task automatic t_ptr_reset();
    run_line(2,   FB_BASE, 1'b0, -1, 8, "R7 blank line");
    run_line(VBE, FB_BASE, 1'b1, -1, LINE_CYC + 8, "R7 first row again");
  endtask

  task automatic t_enable_off();
    run_line(2, FB_BASE, 1'b0, -1, 8, "R9 rewind");
    enable = 1'b0;
    run_line(VBE,     FB_BASE, 1'b0, -1, LINE_CYC + 8, "R9 disabled line0");
    run_line(VBE + 1, FB_BASE, 1'b0, -1, LINE_CYC + 8, "R9 disabled line1");
    enable = 1'b1;
    run_line(VBE + 2, FB_BASE + STRIDE, 1'b1, -1, LINE_CYC + 8, "R9 pointer kept stepping");
  endtask

  task automatic t_enable_drop();
    run_line(2, FB_BASE, 1'b0, -1, 8, "R10 rewind");
    enable = 1'b1;
    run_line(VBE, FB_BASE, 1'b1, 40, LINE_CYC + 8, "R10 drop mid word");
    enable = 1'b1;
  endtask

  task automatic t_retrigger();
    run_line(2,       FB_BASE, 1'b0, -1, 8, "R11 rewind");
    run_line(VBE,     FB_BASE, 1'b1, -1, 101, "R11 first part");
    run_line(VBE + 1, FB_BASE, 1'b1, -1, LINE_CYC + 8, "R11 restarted line");
    run_line(VBE + 2, FB_BASE + STRIDE, 1'b1, -1, LINE_CYC + 8, "R11 following line");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_outside();
    t_frame();
    t_ptr_reset();
    t_enable_off();
    t_enable_drop();
    t_retrigger();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule